// File: doc/BRIEF.md
# Leakage-Based Retention Error Recovery Classifier

This block runs offline, after a page of multi-level cells has failed error correction because stored charge has leaked away. For every cell it takes two quantized threshold-voltage readings: the one saved when the failure was found, and a second one taken after more retention time has passed. It also takes the cell's normally decoded 2-bit state. Software supplies three settings: the best reference voltage between the two top programmed states, a window half-width, and a leakage threshold.

The block handles one cell per clock. It first tests whether the saved reading falls inside the window around the reference. Such a cell is ambiguous. It then measures how far the voltage fell between the two readings to decide whether the cell leaks fast or slowly. An ambiguous cell that leaks fast must have started higher, so it is given the top state. One that leaks slowly is given the state just below. All other cells keep their decoded state. The rewritten 2-bit states go back to the error corrector for another attempt, and at the end of each page the block reports how many cells were ambiguous and how many it changed.

Top module: `retention_recover`

## Requirements
- R1: A cell is risky when its first reading v0 satisfies lo <= v0 <= hi, where lo = ref - sigma and hi = ref + sigma. Both bounds are inclusive.
- R2: When sigma exceeds ref, lo saturates to 0, so a reading of 0 is risky.
- R3: When ref + sigma exceeds the largest voltage code, hi saturates to that code, so the all-ones reading is risky.
- R4: The drop is v0 - v1 when v0 > v1, and 0 otherwise. A risky cell whose drop is strictly greater than the leak threshold is output as the top state, code 2'b01.
- R5: A risky cell whose drop is at most the leak threshold is output as the state below the top, code 2'b00. This includes a cell whose reading rose between snapshots.
- R6: A cell that is not risky is output with its input state unchanged, for any of the codes 11, 10, 00 or 01.
- R7: out_risky marks a risky cell. out_changed is high exactly when the cell is risky and its output code differs from its input code.
- R8: On the output beat that carries out_last, out_risky_cnt and out_changed_cnt give the page's totals, counting that last cell. The totals restart from zero for the next page.
- R9: in_ready is high whenever the output register is empty or out_ready is high. While out_valid is high and out_ready is low, every output holds steady. Cells leave the block in the order they arrived, and none is lost.
- R10: After reset, out_valid is low, both counts are zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ref | input | VW | Best reference between the two top states |
| cfg_sigma | input | VW | Half-width of the risky window |
| cfg_leak_thr | input | VW | Drop above which a cell counts as fast-leaking |
| in_valid | input | 1 | Input cell valid |
| in_ready | output | 1 | Block accepts a cell |
| in_v0 | input | VW | Saved (first) reading |
| in_v1 | input | VW | Later (second) reading |
| in_state | input | 2 | Normally decoded state |
| in_last | input | 1 | Last cell of the page |
| out_valid | output | 1 | Output cell valid |
| out_ready | input | 1 | Downstream accepts |
| out_state | output | 2 | Recovered state |
| out_risky | output | 1 | Cell was in the window |
| out_changed | output | 1 | Cell state was rewritten |
| out_last | output | 1 | Last cell of the page |
| out_risky_cnt | output | CW | Risky cells in the page (valid with out_last) |
| out_changed_cnt | output | CW | Changed cells in the page (valid with out_last) |

## Verification
On every cycle, the assertions check the following:
- outputs hold steady during a stall;
- an empty output stage always accepts input;
- a changed cell is always risky, and a risky cell only ever carries one of the two top codes;
- a page's changed total never exceeds its risky total.

Whether each cell was classified correctly can only be shown by the bench's scenarios. Those scenarios cover the exact inclusive window edges, both saturation cases, a drop equal to the threshold, a reading that rose, and per-page totals under random backpressure.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    ST_ER = 2'b11,
    ST_P1 = 2'b10,
    ST_P2 = 2'b00,
    ST_P3 = 2'b01
  } cell_state_e;
endpackage

// File: rtl/rrc_window.sv
module rrc_window #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] ref_v,
  input  logic [VW-1:0] sigma,
  output logic [VW-1:0] lo,
  output logic [VW-1:0] hi
);
  logic [VW:0] sum;

  always_comb begin
    sum = {1'b0, ref_v} + {1'b0, sigma};
    hi  = sum[VW] ? {VW{1'b1}} : sum[VW-1:0];
    lo  = (ref_v >= sigma) ? (ref_v - sigma) : '0;
  end
endmodule

// File: rtl/rrc_cell_decide.sv
module rrc_cell_decide
  import rrc_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic [VW-1:0] v0,
  input  logic [VW-1:0] v1,
  input  logic [VW-1:0] lo,
  input  logic [VW-1:0] hi,
  input  logic [VW-1:0] thr,
  input  logic [1:0]    st_in,
  output logic          risky,
  output logic          changed,
  output logic [1:0]    st_out
);
  logic [VW-1:0] drop;
  logic          fast;
  logic [1:0]    guess;

  always_comb begin
    drop    = (v0 > v1) ? (v0 - v1) : '0;
    risky   = (v0 >= lo) && (v0 <= hi);
    fast    = drop > thr;
    guess   = fast ? ST_P3 : ST_P2;
    st_out  = risky ? guess : st_in;
    changed = risky && (guess != st_in);
  end
endmodule

// File: rtl/rrc_page_count.sv
module rrc_page_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          risky,
  input  logic          changed,
  input  logic          last,
  output logic [CW-1:0] tot_risky,
  output logic [CW-1:0] tot_changed
);
  logic [CW-1:0] acc_r_q, acc_c_q, acc_r_d, acc_c_d;

  always_comb begin
    tot_risky   = acc_r_q + CW'(risky);
    tot_changed = acc_c_q + CW'(changed);
    acc_r_d     = acc_r_q;
    acc_c_d     = acc_c_q;
    if (en) begin
      acc_r_d = last ? '0 : tot_risky;
      acc_c_d = last ? '0 : tot_changed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r_q <= '0;
      acc_c_q <= '0;
    end else begin
      acc_r_q <= acc_r_d;
      acc_c_q <= acc_c_d;
    end
  end
endmodule

// File: rtl/retention_recover.sv
module retention_recover #(
  parameter int VW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] cfg_ref,
  input  logic [VW-1:0] cfg_sigma,
  input  logic [VW-1:0] cfg_leak_thr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_v0,
  input  logic [VW-1:0] in_v1,
  input  logic [1:0]    in_state,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_state,
  output logic          out_risky,
  output logic          out_changed,
  output logic          out_last,
  output logic [CW-1:0] out_risky_cnt,
  output logic [CW-1:0] out_changed_cnt
);
  logic [VW-1:0] win_lo, win_hi;
  logic          c_risky, c_changed;
  logic [1:0]    c_state;
  logic [CW-1:0] sum_risky, sum_changed;
  logic          accept;

  logic          vld_q, vld_d;
  logic [1:0]    st_q, st_d;
  logic          rk_q, rk_d, ch_q, ch_d, ls_q, ls_d;
  logic [CW-1:0] rc_q, rc_d, cc_q, cc_d;

  rrc_window #(.VW(VW)) u_win (
    .ref_v(cfg_ref), .sigma(cfg_sigma), .lo(win_lo), .hi(win_hi)
  );

  rrc_cell_decide #(.VW(VW)) u_dec (
    .v0(in_v0), .v1(in_v1), .lo(win_lo), .hi(win_hi), .thr(cfg_leak_thr),
    .st_in(in_state), .risky(c_risky), .changed(c_changed), .st_out(c_state)
  );

  rrc_page_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(accept), .risky(c_risky),
    .changed(c_changed), .last(in_last),
    .tot_risky(sum_risky), .tot_changed(sum_changed)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    st_d  = st_q;
    rk_d  = rk_q;
    ch_d  = ch_q;
    ls_d  = ls_q;
    rc_d  = rc_q;
    cc_d  = cc_q;
    if (accept) begin
      vld_d = 1'b1;
      st_d  = c_state;
      rk_d  = c_risky;
      ch_d  = c_changed;
      ls_d  = in_last;
      if (in_last) begin
        rc_d = sum_risky;
        cc_d = sum_changed;
      end
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      st_q  <= 2'b00;
      rk_q  <= 1'b0;
      ch_q  <= 1'b0;
      ls_q  <= 1'b0;
      rc_q  <= '0;
      cc_q  <= '0;
    end else begin
      vld_q <= vld_d;
      st_q  <= st_d;
      rk_q  <= rk_d;
      ch_q  <= ch_d;
      ls_q  <= ls_d;
      rc_q  <= rc_d;
      cc_q  <= cc_d;
    end
  end

  assign out_valid       = vld_q;
  assign out_state       = st_q;
  assign out_risky       = rk_q;
  assign out_changed     = ch_q;
  assign out_last        = ls_q;
  assign out_risky_cnt   = rc_q;
  assign out_changed_cnt = cc_q;
endmodule

// File: rtl/retention_recover_chk.sv
module retention_recover_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_state,
  input logic          out_risky,
  input logic          out_changed,
  input logic          out_last,
  input logic [CW-1:0] out_risky_cnt,
  input logic [CW-1:0] out_changed_cnt
);
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state) && $stable(out_risky)
      && $stable(out_changed) && $stable(out_last) && $stable(out_risky_cnt)
      && $stable(out_changed_cnt)));

  p_empty_accepts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_change_needs_risk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_changed) |-> out_risky);

  p_risky_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_risky) |-> (out_state == 2'b00 || out_state == 2'b01));

  p_cnt_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_changed_cnt <= out_risky_cnt));
endmodule

bind retention_recover retention_recover_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_state(out_state), .out_risky(out_risky),
  .out_changed(out_changed), .out_last(out_last),
  .out_risky_cnt(out_risky_cnt), .out_changed_cnt(out_changed_cnt)
);

// File: tb/retention_recover_tb_top.sv
module retention_recover_tb_top;
  localparam int VW = 8;
  localparam int CW = 16;
  localparam int VMAX = (1 << VW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0] cfg_ref = '0, cfg_sigma = '0, cfg_leak_thr = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [VW-1:0] in_v0 = '0, in_v1 = '0;
  logic [1:0] in_state = 2'b11;
  logic in_ready, out_valid, out_risky, out_changed, out_last;
  logic [1:0] out_state;
  logic [CW-1:0] out_risky_cnt, out_changed_cnt;

  always #2.5 clk = ~clk;

  retention_recover #(.VW(VW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ref(cfg_ref), .cfg_sigma(cfg_sigma),
    .cfg_leak_thr(cfg_leak_thr), .in_valid(in_valid), .in_ready(in_ready),
    .in_v0(in_v0), .in_v1(in_v1), .in_state(in_state), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state),
    .out_risky(out_risky), .out_changed(out_changed), .out_last(out_last),
    .out_risky_cnt(out_risky_cnt), .out_changed_cnt(out_changed_cnt)
  );

  typedef struct {
    logic [1:0] st;
    logic       rk;
    logic       ch;
    logic       ls;
    int         rc;
    int         cc;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_tests = 0, n_fail = 0;
  int pg_r = 0, pg_c = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send_cell(input int v0, input int v1, input logic [1:0] st,
                           input bit last, input string tag);
    exp_t e;
    int lo, hi, drop;
    bit rk, fast;
    logic [1:0] g;
    lo   = (cfg_ref >= cfg_sigma) ? int'(cfg_ref) - int'(cfg_sigma) : 0;
    hi   = int'(cfg_ref) + int'(cfg_sigma);
    if (hi > VMAX) hi = VMAX;
    rk   = (v0 >= lo) && (v0 <= hi);
    drop = (v0 > v1) ? v0 - v1 : 0;
    fast = drop > int'(cfg_leak_thr);
    g    = fast ? 2'b01 : 2'b00;
    e.st = rk ? g : st;
    e.rk = rk;
    e.ch = rk && (g != st);
    e.ls = last;
    pg_r += int'(e.rk);
    pg_c += int'(e.ch);
    e.rc = pg_r;
    e.cc = pg_c;
    e.tag = tag;
    if (last) begin
      pg_r = 0;
      pg_c = 0;
    end
    q.push_back(e);
    forever begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_v0     = v0[VW-1:0];
      in_v1     = v1[VW-1:0];
      in_state  = st;
      in_last   = last;
      out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (in_ready) break;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      guard++;
    end
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per completed output handshake.
  bit stall_prev = 1'b0;
  logic [1:0] s_st;
  logic s_rk, s_ch, s_ls;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (stall_prev) begin
          check(out_valid && out_state == s_st && out_risky == s_rk &&
                out_changed == s_ch && out_last == s_ls, "R9", "stall hold",
                int'(out_state), int'(s_st));
        end
        stall_prev = out_valid && !out_ready;
        s_st = out_state; s_rk = out_risky; s_ch = out_changed; s_ls = out_last;
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R9", "unexpected output beat", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(out_state == e.st, e.tag, "state", int'(out_state), int'(e.st));
            check(out_risky == e.rk, {e.tag, " R7"}, "risky flag", int'(out_risky), int'(e.rk));
            check(out_changed == e.ch, {e.tag, " R7"}, "changed flag", int'(out_changed), int'(e.ch));
            check(out_last == e.ls, "R9", "last flag", int'(out_last), int'(e.ls));
            if (e.ls) begin
              check(int'(out_risky_cnt) == e.rc, "R8", "risky count", int'(out_risky_cnt), e.rc);
              check(int'(out_changed_cnt) == e.cc, "R8", "changed count", int'(out_changed_cnt), e.cc);
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    check(out_risky_cnt == '0 && out_changed_cnt == '0, "R10", "counts after reset",
          int'(out_risky_cnt), 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);

    // Page 1: window 90..110, threshold 5
    cfg_ref = 8'd100; cfg_sigma = 8'd10; cfg_leak_thr = 8'd5;
    send_cell(90, 80, 2'b00, 1'b0, "R1 R4");
    send_cell(110, 109, 2'b01, 1'b0, "R1 R5");
    send_cell(89, 50, 2'b00, 1'b0, "R1 R6");
    send_cell(111, 10, 2'b01, 1'b0, "R1 R6");
    send_cell(100, 95, 2'b01, 1'b0, "R5");
    send_cell(100, 94, 2'b00, 1'b0, "R4");
    send_cell(100, 120, 2'b01, 1'b0, "R5");
    send_cell(20, 5, 2'b11, 1'b0, "R6");
    send_cell(60, 55, 2'b10, 1'b0, "R6");
    send_cell(200, 100, 2'b01, 1'b1, "R6");
    drain();

    // Page 2: low bound saturates
    cfg_ref = 8'd5; cfg_sigma = 8'd20; cfg_leak_thr = 8'd3;
    send_cell(0, 0, 2'b11, 1'b0, "R2");
    send_cell(25, 10, 2'b10, 1'b0, "R2");
    send_cell(26, 0, 2'b10, 1'b1, "R2 R6");
    drain();

    // Page 3: high bound saturates
    cfg_ref = 8'd250; cfg_sigma = 8'd20; cfg_leak_thr = 8'd2;
    send_cell(255, 250, 2'b00, 1'b0, "R3");
    send_cell(230, 229, 2'b01, 1'b0, "R3");
    send_cell(229, 100, 2'b00, 1'b1, "R3 R6");
    drain();

    // Page 4: random cells under backpressure
    cfg_ref = 8'd128; cfg_sigma = 8'd16; cfg_leak_thr = 8'd8;
    bp_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      int a, b;
      a = 96 + ($urandom % 64);
      b = a - 20 + ($urandom % 40);
      if (b < 0) b = 0;
      if (b > VMAX) b = VMAX;
      send_cell(a, b, 2'($urandom), (i == 199), "R9 R1");
    end
    // Page 5: short page right after, counts restart
    send_cell(128, 100, 2'b00, 1'b0, "R8 R4");
    send_cell(128, 128, 2'b00, 1'b1, "R8 R5");
    bp_en = 1'b0;
    drain();

    check(q.size() == 0, "R9", "items left in queue", q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule